// File: doc/BRIEF.md
# Video Memory Byte Write Port with Address Remap

This block is the processor-facing write path into a 64 KB video memory organised as 32K words of 16 bits. Software first loads a 15-bit word address. It then pushes bytes through two strobed ports, one for the even (low) byte and one for the odd (high) byte of the addressed word. Each accepted byte leaves the block as a one-cycle write strobe, a 16-bit byte address and the data byte, all registered.

After each accepted byte, the word address can step forward by a programmable amount (1, 32 or 128). A mode flag chooses whether the low-byte port or the high-byte port triggers the step. An optional remap stage rotates the low bits of the word address before it reaches memory. This lets a linear stream of bytes land in a bitplane-interleaved layout.

A blanking gate drops writes while the beam is inside the visible picture, unless forced blanking is on. A dropped write does not advance the address either.

Top module: `vram_wr_port`

## Requirements
- R1: While `rst` is high and after it falls, `word_addr` reads 0 and `mem_we` is 0 until the first accepted write.
- R2: A one-cycle `addr_set` pulse makes `word_addr` equal `addr_val` on the next cycle, and this takes priority over any advance in the same cycle.
- R3: With remap off (`remap_mode` = 00), a write on the low port produces byte address `word_addr*2`, and a write on the high port produces `word_addr*2 + 1`, both carrying `wr_data`.
- R4: When `inc_on_hi` = 0, an accepted low-port write advances the address and a high-port write does not. When `inc_on_hi` = 1, the roles swap.
- R5: `step_sel` encodes the step: 00 is 1 word, 01 is 32 words, and 10 or 11 is 128 words.
- R6: The word address is 15 bits and wraps modulo 32768.
- R7: `remap_mode` = 01, 10 or 11 selects n = 5, 6 or 7. With mask = 2^(n+3) - 1, the word address A becomes `(A & ~mask) + ((A & mask) >> n) + (((A & mask) mod 2^n) << 3)` before the byte bit is appended.
- R8: A write is blocked when `block_en` = 1, `force_blank` = 0 and `scanline < screen_height + 1`. A blocked write raises no `mem_we` and leaves `word_addr` unchanged.
- R9: The gate is open when `block_en` = 0, or `force_blank` = 1, or `scanline >= screen_height + 1`.
- R10: If `wr_lo` and `wr_hi` are both high in one cycle, only the low byte is written and the high-port request is discarded, including its advance.
- R11: `mem_we` is high for exactly the one cycle after an accepted strobe cycle. The address and data are registered alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_set | input | 1 | Load the word address from `addr_val` |
| addr_val | input | 15 | Word address to load |
| step_sel | input | 2 | Advance step select (00: 1, 01: 32, 1x: 128) |
| inc_on_hi | input | 1 | 0: low port advances, 1: high port advances |
| remap_mode | input | 2 | 00 off, 01/10/11 rotate by 5/6/7 bits |
| wr_lo | input | 1 | Low-byte write strobe |
| wr_hi | input | 1 | High-byte write strobe |
| wr_data | input | 8 | Byte to write |
| block_en | input | 1 | Enable the active-display write block |
| force_blank | input | 1 | Forced blanking active |
| scanline | input | 9 | Current scanline |
| screen_height | input | 9 | Number of visible lines |
| mem_we | output | 1 | Byte write strobe to memory |
| mem_addr | output | 16 | Byte address to memory |
| mem_data | output | 8 | Byte data to memory |
| word_addr | output | 15 | Current word address |

## Verification
The bench builds the block with its default parameters: a 15-bit word address, 8-bit data, 9-bit line counters and the first visible line at 1. With a full 15-bit address, the top-of-space wrap at 0x7FFF is reachable with a single address load. Each of the three remap widths fits below the address width, so all four remap modes can be checked against hand-computed addresses, including one at the edge of a mask field. The 9-bit line inputs allow a 224-line screen, so the blanking boundary can be checked on lines 224 and 225.

// File: rtl/vwp_pkg.sv
package vwp_pkg;

    typedef enum logic [1:0] {
        STEP_ONE    = 2'b00,
        STEP_ROW    = 2'b01,
        STEP_BLOCK  = 2'b10,
        STEP_BLOCK2 = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        MAP_OFF  = 2'b00,
        MAP_N5   = 2'b01,
        MAP_N6   = 2'b10,
        MAP_N7   = 2'b11
    } remap_e;

    localparam int unsigned REMAP_BASE_SHIFT = 4;
    localparam int unsigned REMAP_FIELD_POS  = 3;

    typedef struct packed {
        logic take;
        logic odd;
    } byte_req_t;

    function automatic int unsigned step_log2(step_e s);
        case (s)
            STEP_ONE: return 0;
            STEP_ROW: return 5;
            default:  return 7;
        endcase
    endfunction

endpackage

// File: rtl/vwp_gate.sv
module vwp_gate #(
    parameter int LINE_W     = 9,
    parameter int FIRST_LINE = 1
) (
    input  logic              block_en,
    input  logic              force_blank,
    input  logic [LINE_W-1:0] scanline,
    input  logic [LINE_W-1:0] screen_height,
    output logic              gate_open
);
    localparam int CMP_W = LINE_W + 1;

    logic [CMP_W-1:0] line_ext;
    logic [CMP_W-1:0] limit_ext;
    logic             in_picture;

    always_comb begin
        line_ext   = {1'b0, scanline};
        limit_ext  = {1'b0, screen_height} + CMP_W'(FIRST_LINE);
        in_picture = line_ext < limit_ext;
        gate_open  = !(block_en && !force_blank && in_picture);
    end
endmodule

// File: rtl/vwp_addr_ctr.sv
module vwp_addr_ctr
    import vwp_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              advance,
    input  step_e             step_sel,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] step_amt;

    always_comb begin
        step_amt = ADDR_W'(1) << step_log2(step_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (advance) begin
            addr <= addr + step_amt;
        end
    end
endmodule

// File: rtl/vwp_remap.sv
module vwp_remap
    import vwp_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  remap_e            mode,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int MODES = 4;

    logic [ADDR_W-1:0] cand [MODES];

    assign cand[0] = addr_in;

    for (genvar g = 1; g < MODES; g++) begin : g_mode
        localparam int SH = REMAP_BASE_SHIFT + g;
        localparam logic [ADDR_W-1:0] FIELD_MASK = ADDR_W'((1 << (SH + REMAP_FIELD_POS)) - 1);
        localparam logic [ADDR_W-1:0] LOW_MASK   = ADDR_W'((1 << SH) - 1);

        logic [ADDR_W-1:0] field;
        logic [ADDR_W-1:0] upper;
        logic [ADDR_W-1:0] moved_down;
        logic [ADDR_W-1:0] moved_up;

        always_comb begin
            field      = addr_in & FIELD_MASK;
            upper      = addr_in & ~FIELD_MASK;
            moved_down = field >> SH;
            moved_up   = (field & LOW_MASK) << REMAP_FIELD_POS;
            cand[g]    = upper + moved_down + moved_up;
        end
    end

    always_comb begin
        addr_out = cand[mode];
    end
endmodule

// File: rtl/vram_wr_port.sv
module vram_wr_port
    import vwp_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int LINE_W     = 9,
    parameter int FIRST_LINE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_set,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic [1:0]        step_sel,
    input  logic              inc_on_hi,
    input  logic [1:0]        remap_mode,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              block_en,
    input  logic              force_blank,
    input  logic [LINE_W-1:0] scanline,
    input  logic [LINE_W-1:0] screen_height,
    output logic              mem_we,
    output logic [ADDR_W:0]   mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] word_addr
);
    logic              gate_open;
    byte_req_t         req;
    logic              advance;
    logic [ADDR_W-1:0] xlat_addr;

    vwp_gate #(
        .LINE_W     (LINE_W),
        .FIRST_LINE (FIRST_LINE)
    ) u_gate (
        .block_en      (block_en),
        .force_blank   (force_blank),
        .scanline      (scanline),
        .screen_height (screen_height),
        .gate_open     (gate_open)
    );

    // Low port wins a same-cycle collision; the gate qualifies both.
    always_comb begin
        req.take = (wr_lo || wr_hi) && gate_open;
        req.odd  = !wr_lo;
        advance  = req.take && (req.odd == inc_on_hi);
    end

    vwp_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_set),
        .load_val (addr_val),
        .advance  (advance),
        .step_sel (step_e'(step_sel)),
        .addr     (word_addr)
    );

    vwp_remap #(
        .ADDR_W (ADDR_W)
    ) u_remap (
        .addr_in  (word_addr),
        .mode     (remap_e'(remap_mode)),
        .addr_out (xlat_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            mem_we <= req.take;
            if (req.take) begin
                mem_addr <= {xlat_addr, req.odd};
                mem_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/vram_wr_port_chk.sv
module vram_wr_port_chk #(
    parameter int ADDR_W = 15,
    parameter int LINE_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_set,
    input logic [ADDR_W-1:0] addr_val,
    input logic              wr_lo,
    input logic              wr_hi,
    input logic              block_en,
    input logic              force_blank,
    input logic [LINE_W-1:0] scanline,
    input logic [LINE_W-1:0] screen_height,
    input logic              mem_we,
    input logic [ADDR_W:0]   mem_addr,
    input logic [ADDR_W-1:0] word_addr
);
    logic blk;
    assign blk = block_en && !force_blank &&
                 ({1'b0, scanline} < ({1'b0, screen_height} + (LINE_W+1)'(1)));

    // R11
    we_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(wr_lo || wr_hi));

    // R8
    blocked_no_we_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_lo || wr_hi) && blk) |=> !mem_we);

    // R8
    blocked_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_lo || wr_hi) && blk && !addr_set) |=> $stable(word_addr));

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (rst)
        addr_set |=> (word_addr == $past(addr_val)));

    // R10
    low_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && wr_hi && !blk) |=> (mem_we && !mem_addr[0]));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_lo && !wr_hi && !addr_set) |=> $stable(word_addr));
endmodule

bind vram_wr_port vram_wr_port_chk #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W)
) u_vram_wr_port_chk (
    .clk           (clk),
    .rst           (rst),
    .addr_set      (addr_set),
    .addr_val      (addr_val),
    .wr_lo         (wr_lo),
    .wr_hi         (wr_hi),
    .block_en      (block_en),
    .force_blank   (force_blank),
    .scanline      (scanline),
    .screen_height (screen_height),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .word_addr     (word_addr)
);

// File: tb/test_vram_wr_port.sv
module test_vram_wr_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        addr_set;
    logic [14:0] addr_val;
    logic [1:0]  step_sel;
    logic        inc_on_hi;
    logic [1:0]  remap_mode;
    logic        wr_lo;
    logic        wr_hi;
    logic [7:0]  wr_data;
    logic        block_en;
    logic        force_blank;
    logic [8:0]  scanline;
    logic [8:0]  screen_height;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic [14:0] word_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vram_wr_port i_vram_wr_port (
        .clk           (clk),
        .rst           (rst),
        .addr_set      (addr_set),
        .addr_val      (addr_val),
        .step_sel      (step_sel),
        .inc_on_hi     (inc_on_hi),
        .remap_mode    (remap_mode),
        .wr_lo         (wr_lo),
        .wr_hi         (wr_hi),
        .wr_data       (wr_data),
        .block_en      (block_en),
        .force_blank   (force_blank),
        .scanline      (scanline),
        .screen_height (screen_height),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_data      (mem_data),
        .word_addr     (word_addr)
    );

    task automatic check(string tag, int unsigned got, int unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic load_addr(logic [14:0] a);
        @(negedge clk);
        addr_set = 1'b1;
        addr_val = a;
        @(negedge clk);
        addr_set = 1'b0;
    endtask

    // Drive one strobe cycle; returns at the next falling edge, when outputs are settled.
    task automatic push(logic lo, logic hi, logic [7:0] d);
        @(negedge clk);
        wr_lo   = lo;
        wr_hi   = hi;
        wr_data = d;
        @(negedge clk);
        wr_lo = 1'b0;
        wr_hi = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 word_addr after reset", word_addr, 0);
        check("R1 mem_we after reset", mem_we, 0);
    endtask

    task automatic t_linear;
        remap_mode = 2'b00; step_sel = 2'b00; inc_on_hi = 1'b0;
        load_addr(15'h0123);
        check("R2 load", word_addr, 16'h0123);
        push(1'b1, 1'b0, 8'hA5);
        check("R3 low we", mem_we, 1);
        check("R3 low addr", mem_addr, 16'h0246);
        check("R3 low data", mem_data, 8'hA5);
        @(negedge clk);
        check("R11 we single pulse", mem_we, 0);
        push(1'b0, 1'b1, 8'h3C);
        check("R3 high addr", mem_addr, 16'h0249);
        check("R3 high data", mem_data, 8'h3C);
    endtask

    task automatic t_inc_mode;
        step_sel = 2'b00; remap_mode = 2'b00;
        inc_on_hi = 1'b0;
        load_addr(15'h0100);
        push(1'b1, 1'b0, 8'h01);
        check("R4 lo-mode lo advances", word_addr, 16'h0101);
        push(1'b0, 1'b1, 8'h02);
        check("R4 lo-mode hi addr", mem_addr, 16'h0203);
        check("R4 lo-mode hi holds", word_addr, 16'h0101);
        inc_on_hi = 1'b1;
        load_addr(15'h0100);
        push(1'b1, 1'b0, 8'h03);
        check("R4 hi-mode lo holds", word_addr, 16'h0100);
        push(1'b0, 1'b1, 8'h04);
        check("R4 hi-mode hi addr", mem_addr, 16'h0201);
        check("R4 hi-mode hi advances", word_addr, 16'h0101);
        inc_on_hi = 1'b0;
    endtask

    task automatic t_steps;
        remap_mode = 2'b00; inc_on_hi = 1'b0;
        load_addr(15'h0010);
        step_sel = 2'b01; push(1'b1, 1'b0, 8'h00);
        check("R5 step 32", word_addr, 16'h0030);
        step_sel = 2'b10; push(1'b1, 1'b0, 8'h00);
        check("R5 step 128", word_addr, 16'h00B0);
        step_sel = 2'b11; push(1'b1, 1'b0, 8'h00);
        check("R5 step 128 alt code", word_addr, 16'h0130);
    endtask

    task automatic t_wrap;
        remap_mode = 2'b00; inc_on_hi = 1'b0;
        step_sel = 2'b00;
        load_addr(15'h7FFF);
        push(1'b1, 1'b0, 8'h11);
        check("R6 top byte addr", mem_addr, 16'hFFFE);
        check("R6 wrap by 1", word_addr, 0);
        step_sel = 2'b10;
        load_addr(15'h7FF0);
        push(1'b1, 1'b0, 8'h22);
        check("R6 wrap by 128", word_addr, 16'h0070);
    endtask

    task automatic t_remap;
        step_sel = 2'b00; inc_on_hi = 1'b0;
        remap_mode = 2'b01;
        load_addr(15'h0001);
        push(1'b1, 1'b0, 8'h40);
        check("R7 n5 addr 0x0001", mem_addr, 16'h0010);
        check("R7 counter stays linear", word_addr, 16'h0002);
        load_addr(15'h0020);
        push(1'b1, 1'b0, 8'h41);
        check("R7 n5 addr 0x0020", mem_addr, 16'h0002);
        load_addr(15'h12FF);
        push(1'b1, 1'b0, 8'h42);
        check("R7 n5 field edge", mem_addr, 16'h25FE);
        remap_mode = 2'b10;
        load_addr(15'h0123);
        push(1'b0, 1'b1, 8'h43);
        check("R7 n6 high byte", mem_addr, 16'h0239);
        remap_mode = 2'b11;
        load_addr(15'h0081);
        push(1'b1, 1'b0, 8'h44);
        check("R7 n7", mem_addr, 16'h0012);
        remap_mode = 2'b00;
    endtask

    task automatic t_block;
        step_sel = 2'b00; inc_on_hi = 1'b0; remap_mode = 2'b00;
        screen_height = 9'd224;
        block_en = 1'b1; force_blank = 1'b0;
        load_addr(15'h0200);
        scanline = 9'd10;
        push(1'b1, 1'b0, 8'h55);
        check("R8 blocked no we", mem_we, 0);
        check("R8 blocked no advance", word_addr, 16'h0200);
        scanline = 9'd224;
        push(1'b1, 1'b0, 8'h56);
        check("R8 last visible line blocked", mem_we, 0);
        check("R8 last visible line no advance", word_addr, 16'h0200);
        scanline = 9'd225;
        push(1'b1, 1'b0, 8'h57);
        check("R9 first blank line open", mem_we, 1);
        check("R9 first blank line advance", word_addr, 16'h0201);
        scanline = 9'd10; force_blank = 1'b1;
        push(1'b0, 1'b1, 8'h58);
        check("R9 forced blank open", mem_we, 1);
        check("R9 forced blank addr", mem_addr, 16'h0403);
        force_blank = 1'b0; block_en = 1'b0;
        push(1'b1, 1'b0, 8'h59);
        check("R9 block disabled open", mem_we, 1);
        check("R9 block disabled advance", word_addr, 16'h0202);
        scanline = 9'd0;
    endtask

    task automatic t_both;
        step_sel = 2'b00; remap_mode = 2'b00; inc_on_hi = 1'b1;
        load_addr(15'h0040);
        push(1'b1, 1'b1, 8'h5A);
        check("R10 low byte written", mem_addr, 16'h0080);
        check("R10 data", mem_data, 8'h5A);
        check("R10 high advance discarded", word_addr, 16'h0040);
        inc_on_hi = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr_set = 1'b0; addr_val = '0; step_sel = 2'b00;
        inc_on_hi = 1'b0; remap_mode = 2'b00; wr_lo = 1'b0; wr_hi = 1'b0;
        wr_data = '0; block_en = 1'b0; force_blank = 1'b0;
        scanline = '0; screen_height = 9'd224;
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_linear;
        t_inc_mode;
        t_steps;
        t_wrap;
        t_remap;
        t_block;
        t_both;
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule